// File: doc/BRIEF.md
# Torus Dimension-Order Packet Steering Unit

This unit sits on one input channel of a two-dimensional torus node, either the channel from the neighbour in the x direction or the channel from the local processor. Packets arrive as a stream of 8-bit flits. Each packet opens with two relative hop counts, first x and then y. One or more non-zero payload flits follow, and a single zero flit closes the packet. The unit reads the hop counts and sends the whole packet to exactly one of three outputs: the next node in x, the next node in y, or the local processor.

The header is rewritten on the way through. A non-zero x count is decremented and forwarded on the x output. The y count then follows it on the x output unchanged. A zero x count is removed from the stream. In that case a non-zero y count is decremented and the packet goes out on the y output. If both counts are zero, both are removed and only the payload and the closing zero reach the processor.

Every port uses a valid/ready handshake. The data path from input to output is combinational. The chosen output stays bound to the packet until its closing flit has been taken. While that output is not ready, the input is held.

Top module: `torus_route_unit`

## Requirements
- R1: A synchronous active-high reset returns the unit to waiting for an x hop count. The first flit accepted after reset, even one that arrives in the middle of an earlier packet, is taken as an x hop count.
- R2: A non-zero x hop count is sent on the x output with its value reduced by one.
- R3: After a forwarded x hop count, the next flit (the y hop count) is sent on the x output unchanged, even when it is zero. All later flits up to and including the closing zero flit follow on the x output.
- R4: A zero x hop count is consumed: in_ready is 1 and no output is valid in that cycle.
- R5: After a dropped x hop count, a non-zero y hop count is sent on the y output reduced by one. The payload and the closing zero flit follow on the y output.
- R6: When both hop counts are zero, the y hop count is also consumed with no output valid. The payload and the closing zero flit are sent on the processor output.
- R7: While the selected output's ready is 0, in_ready is 0 and the flit is held. No flit is lost, repeated or reordered.
- R8: The output chosen by a packet stays in use until its closing zero flit has been accepted. The next flit is then taken as a new x hop count.
- R9: At most one output valid is 1 in any cycle. A flit moves only in a cycle where in_valid is 1 and the selected output is ready (or the flit is being dropped).
- R10: Output valid and data follow in_valid and in_flit in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_flit | input | 8 | Incoming flit |
| in_valid | input | 1 | Incoming flit is valid |
| in_ready | output | 1 | Unit accepts the incoming flit this cycle |
| xo_flit | output | 8 | Flit toward the next node in x |
| xo_valid | output | 1 | x output flit valid |
| xo_ready | input | 1 | x neighbour can accept |
| yo_flit | output | 8 | Flit toward the next node in y |
| yo_valid | output | 1 | y output flit valid |
| yo_ready | input | 1 | y neighbour can accept |
| po_flit | output | 8 | Flit to the local processor |
| po_valid | output | 1 | Processor output flit valid |
| po_ready | input | 1 | Processor can accept |

## Verification
The routing choice and the rewritten flit appear at the outputs in the same cycle the input flit is presented. The packet state moves on only at the clock edge that completes a handshake. The bench therefore drives each flit just after a falling edge, samples in_ready and all three outputs one nanosecond later, still before the next rising edge, and repeats that sampling on every stalled cycle until the selected output accepts. Expected output, value and drop behaviour are worked out for each flit from the hop counts, across a sweep of hop count values, payload lengths and backpressure patterns, plus a reset applied in the middle of a packet.

// File: rtl/torus_rt_pkg.sv
package torus_rt_pkg;

    localparam int FLIT_W_DEF = 8;
    localparam int NUM_OUT    = 3;

    // where the packet is within its header
    typedef enum logic [1:0] {
        ST_XHDR  = 2'd0,
        ST_YHDR  = 2'd1,
        ST_YPASS = 2'd2,
        ST_BODY  = 2'd3
    } rt_state_e;

    // destination; value minus one is the output index
    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_X    = 2'd1,
        DST_Y    = 2'd2,
        DST_PROC = 2'd3
    } rt_dst_e;

    typedef struct packed {
        rt_state_e state;
        rt_dst_e   dst;
    } rt_ctx_t;

    localparam rt_ctx_t CTX_IDLE = '{state: ST_XHDR, dst: DST_NONE};

    function automatic rt_dst_e dst_of_index(input int idx);
        return rt_dst_e'(idx + 1);
    endfunction

endpackage

// File: rtl/rt_hdr_decode.sv
module rt_hdr_decode
    import torus_rt_pkg::*;
#(
    parameter int W = FLIT_W_DEF
) (
    input  rt_ctx_t        ctx,
    input  logic [W-1:0]   flit,
    output rt_dst_e        dst,
    output logic           drop,
    output logic [W-1:0]   out_flit,
    output rt_ctx_t        ctx_nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic flit_zero;
    assign flit_zero = (flit == '0);

    always_comb begin
        dst      = ctx.dst;
        drop     = 1'b0;
        out_flit = flit;
        ctx_nxt  = ctx;
        unique case (ctx.state)
            ST_XHDR: begin
                if (!flit_zero) begin
                    dst      = DST_X;
                    out_flit = flit - ONE;
                    ctx_nxt  = '{state: ST_YPASS, dst: DST_X};
                end else begin
                    dst     = DST_NONE;
                    drop    = 1'b1;
                    ctx_nxt = '{state: ST_YHDR, dst: DST_NONE};
                end
            end
            ST_YHDR: begin
                if (!flit_zero) begin
                    dst      = DST_Y;
                    out_flit = flit - ONE;
                    ctx_nxt  = '{state: ST_BODY, dst: DST_Y};
                end else begin
                    dst     = DST_NONE;
                    drop    = 1'b1;
                    ctx_nxt = '{state: ST_BODY, dst: DST_PROC};
                end
            end
            ST_YPASS: begin
                ctx_nxt = '{state: ST_BODY, dst: ctx.dst};
            end
            ST_BODY: begin
                if (flit_zero) ctx_nxt = CTX_IDLE;
            end
            default: ctx_nxt = CTX_IDLE;
        endcase
    end

endmodule

// File: rtl/rt_route_fsm.sv
module rt_route_fsm
    import torus_rt_pkg::*;
#(
    parameter int W = FLIT_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [W-1:0]  flit,
    input  rt_ctx_t       ctx_nxt,
    output rt_ctx_t       ctx
);
    always_ff @(posedge clk) begin
        if (rst)       ctx <= CTX_IDLE;
        else if (fire) ctx <= ctx_nxt;
    end

    // R8: closing zero flit in the body returns to x header wait
    a_r8_tail_rearms: assert property (@(posedge clk) disable iff (rst)
        (ctx.state == ST_BODY && fire && flit == '0) |=> (ctx.state == ST_XHDR));

    // R8: body flits that are not the tail keep the chosen output
    a_r8_route_held: assert property (@(posedge clk) disable iff (rst)
        (ctx.state == ST_BODY && !(fire && flit == '0)) |=>
            (ctx.state == ST_BODY && $stable(ctx.dst)));

    // R7: nothing advances without a handshake
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(ctx));

    // R3: the y count forwarded in x mode leads into the body on x
    a_r3_ypass_to_body: assert property (@(posedge clk) disable iff (rst)
        (ctx.state == ST_YPASS && fire) |=> (ctx.state == ST_BODY && ctx.dst == DST_X));

endmodule

// File: rtl/rt_out_demux.sv
module rt_out_demux
    import torus_rt_pkg::*;
#(
    parameter int W     = FLIT_W_DEF,
    parameter int N_OUT = NUM_OUT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     drop,
    input  rt_dst_e                  dst,
    input  logic [W-1:0]             flit,
    input  logic [N_OUT-1:0]         o_ready,
    output logic [N_OUT-1:0]         o_valid,
    output logic [N_OUT-1:0][W-1:0]  o_flit,
    output logic                     in_ready
);
    logic [N_OUT-1:0] hit;

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        assign hit[i]     = (dst == dst_of_index(i));
        assign o_valid[i] = in_valid && !drop && hit[i];
        assign o_flit[i]  = flit;
    end

    assign in_ready = drop || (|(hit & o_ready));

    // R9: never two outputs at once
    a_r9_single_output: assert property (@(posedge clk) disable iff (rst)
        $onehot0(o_valid));

    // R4 / R6: a dropped hop count shows on no output
    a_r4_drop_silent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && drop) |-> (o_valid == '0 && in_ready));

    // R7: a blocked output blocks the input
    a_r7_backpressure: assert property (@(posedge clk) disable iff (rst)
        ((o_valid & ~o_ready) != '0) |-> !in_ready);

endmodule

// File: rtl/torus_route_unit.sv
module torus_route_unit
    import torus_rt_pkg::*;
#(
    parameter int FLIT_W = FLIT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLIT_W-1:0] in_flit,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [FLIT_W-1:0] xo_flit,
    output logic              xo_valid,
    input  logic              xo_ready,
    output logic [FLIT_W-1:0] yo_flit,
    output logic              yo_valid,
    input  logic              yo_ready,
    output logic [FLIT_W-1:0] po_flit,
    output logic              po_valid,
    input  logic              po_ready
);
    rt_ctx_t                      ctx, ctx_nxt;
    rt_dst_e                      dst;
    logic                         drop;
    logic [FLIT_W-1:0]            rw_flit;
    logic [NUM_OUT-1:0]           o_valid, o_ready;
    logic [NUM_OUT-1:0][FLIT_W-1:0] o_flit;
    logic                         fire;

    assign fire = in_valid && in_ready;

    rt_hdr_decode #(.W(FLIT_W)) u_dec (
        .ctx      (ctx),
        .flit     (in_flit),
        .dst      (dst),
        .drop     (drop),
        .out_flit (rw_flit),
        .ctx_nxt  (ctx_nxt)
    );

    rt_route_fsm #(.W(FLIT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .flit    (in_flit),
        .ctx_nxt (ctx_nxt),
        .ctx     (ctx)
    );

    assign o_ready = {po_ready, yo_ready, xo_ready};

    rt_out_demux #(.W(FLIT_W), .N_OUT(NUM_OUT)) u_dmx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .drop     (drop),
        .dst      (dst),
        .flit     (rw_flit),
        .o_ready  (o_ready),
        .o_valid  (o_valid),
        .o_flit   (o_flit),
        .in_ready (in_ready)
    );

    assign xo_valid = o_valid[0];
    assign yo_valid = o_valid[1];
    assign po_valid = o_valid[2];
    assign xo_flit  = o_flit[0];
    assign yo_flit  = o_flit[1];
    assign po_flit  = o_flit[2];

    // R2: a non-zero x count leaves on x one lower
    a_r2_x_decrement: assert property (@(posedge clk) disable iff (rst)
        (ctx.state == ST_XHDR && in_valid && in_flit != '0) |->
            (xo_valid && xo_flit == in_flit - FLIT_W'(1)));

    // R5: a non-zero y count after a dropped x leaves on y one lower
    a_r5_y_decrement: assert property (@(posedge clk) disable iff (rst)
        (ctx.state == ST_YHDR && in_valid && in_flit != '0) |->
            (yo_valid && yo_flit == in_flit - FLIT_W'(1)));

    // R6: processor output only carries body flits
    a_r6_proc_body_only: assert property (@(posedge clk) disable iff (rst)
        po_valid |-> (ctx.state == ST_BODY));

endmodule

// File: tb/torus_route_unit_bench.sv
module torus_route_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_flit = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] xo_flit, yo_flit, po_flit;
    logic       xo_valid, yo_valid, po_valid;
    logic       xo_ready = 1'b1, yo_ready = 1'b1, po_ready = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    int tick   = 0;
    bit stall_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    torus_route_unit u_torus_route_unit (
        .clk(clk), .rst(rst),
        .in_flit(in_flit), .in_valid(in_valid), .in_ready(in_ready),
        .xo_flit(xo_flit), .xo_valid(xo_valid), .xo_ready(xo_ready),
        .yo_flit(yo_flit), .yo_valid(yo_valid), .yo_ready(yo_ready),
        .po_flit(po_flit), .po_valid(po_valid), .po_ready(po_ready)
    );

    always @(posedge clk) tick <= tick + 1;

    // backpressure pattern, changed just after the falling edge
    always @(negedge clk) begin
        xo_ready <= !stall_en || (tick % 3 != 1);
        yo_ready <= !stall_en || (tick % 4 != 2);
        po_ready <= !stall_en || (tick % 5 != 3);
    end

    always @(posedge clk) begin
        if (tick > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish (actual tick %0d, expected < 150000)", tick);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // port: 0 dropped, 1 x, 2 y, 3 processor
    task automatic send_flit(input logic [7:0] b, input int port, input logic [7:0] val,
                             input string req);
        bit moved = 1'b0;
        int waits = 0;
        while (!moved) begin
            @(negedge clk);
            in_flit  = b;
            in_valid = 1'b1;
            #1;
            begin
                bit sel_rdy;
                sel_rdy = (port == 0) ? 1'b1 : (port == 1) ? xo_ready :
                          (port == 2) ? yo_ready : po_ready;
                chk(in_ready == sel_rdy, {req, " R7 in_ready"}, in_ready, sel_rdy);
                chk(xo_valid == (port == 1), {req, " R9/R10 xo_valid"}, xo_valid, port == 1);
                chk(yo_valid == (port == 2), {req, " R9/R10 yo_valid"}, yo_valid, port == 2);
                chk(po_valid == (port == 3), {req, " R9/R10 po_valid"}, po_valid, port == 3);
                if (port == 1) chk(xo_flit == val, {req, " x flit"}, xo_flit, val);
                if (port == 2) chk(yo_flit == val, {req, " y flit"}, yo_flit, val);
                if (port == 3) chk(po_flit == val, {req, " p flit"}, po_flit, val);
                moved = sel_rdy;
            end
            waits++;
            if (waits > 30) begin
                chk(1'b0, {req, " R7 stuck"}, waits, 30);
                moved = 1'b1;
            end
        end
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk({xo_valid, yo_valid, po_valid} == 3'b000, req, {xo_valid, yo_valid, po_valid}, 0);
    endtask

    // payload first byte carries the expected port code
    task automatic send_packet(input logic [7:0] x, input logic [7:0] y, input int len);
        int port;
        port = (x != 0) ? 1 : (y != 0) ? 2 : 3;
        if (x != 0) begin
            send_flit(x, 1, x - 8'd1, "R2 x hop");
            send_flit(y, 1, y, "R3 y pass");
        end else begin
            send_flit(x, 0, 8'd0, "R4 x drop");
            if (y != 0) send_flit(y, 2, y - 8'd1, "R5 y hop");
            else        send_flit(y, 0, 8'd0, "R6 y drop");
        end
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = (i == 0) ? 8'(port) : 8'(8'h40 + i * 37 + x);
            if (d == 0) d = 8'h5A;
            send_flit(d, port, d, (port == 1) ? "R3 body" : (port == 2) ? "R5 body" : "R6 body");
        end
        send_flit(8'd0, port, 8'd0, "R8 tail");
    endtask

    initial begin
        logic [7:0] xs [4] = '{8'd0, 8'd1, 8'd2, 8'd255};
        logic [7:0] ys [4] = '{8'd0, 8'd1, 8'd3, 8'd255};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle_check("R1 reset idle");
        for (int s = 0; s < 2; s++) begin
            stall_en = (s == 1);
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int l = 1; l <= 3; l++)
                        send_packet(xs[a], ys[b], l);
        end
        idle_check("R9 idle after sweep");
        // R1: reset in the middle of an x-routed packet
        stall_en = 1'b0;
        send_flit(8'd5, 1, 8'd4, "R2 pre-reset");
        send_flit(8'd0, 1, 8'd0, "R3 pre-reset y");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle_check("R1 after reset");
        send_flit(8'd0, 0, 8'd0, "R1 header after reset");
        send_flit(8'd2, 2, 8'd1, "R1 y header after reset");
        send_flit(8'd2, 2, 8'd2, "R5 body");
        send_flit(8'd0, 2, 8'd0, "R8 tail");
        // R8: back-to-back packets, zero y count inside x route
        send_packet(8'd3, 8'd0, 2);
        send_packet(8'd0, 8'd0, 1);
        idle_check("R9 final idle");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule